// File: doc/BRIEF.md
# Load/Store Multiple Sequencer

This block turns a single block-transfer instruction into a run of 32-bit memory accesses, one for each general-purpose register. The run starts at a chosen register and ends at the highest register. A store walks the registers and writes each one to the next memory word. A load walks the same way and writes each returned word into its register. The start request carries the first register number, the base register number used to form the address, a direction flag and the effective address. The sequencer produces the word addresses itself, starting at the effective address and stepping by four.

It raises a page-cross indication on the first access that leaves the 4 KB page of the starting address. It stops cleanly when the memory side reports a translation fault on any access. It rejects, before any access, a load whose base register lies inside the set of registers it would overwrite. The translation unit and the exception logic sit outside this block. The block only reports a fault, its address and its one-cycle completion pulses.

Top module: `lsm_seq`

## Requirements
- R1: After an accepted start with first register F, the block issues exactly 32-F accesses, one per register. Each access presents register index F, F+1, ... 31 on rf_raddr_o in that order.
- R2: Access i (counting from 0) uses address ea_i + 4*i. Address, register index and direction stay unchanged from cycle to cycle until the access receives a response.
- R3: A store drives mem_we_o=1 and mem_wdata_o equal to rf_rdata_i of the current register. A load drives mem_we_o=0. In the cycle mem_ack_i is high, it asserts rf_we_o with rf_waddr_o equal to the current register and rf_wdata_o equal to mem_rdata_i.
- R4: page_cross_o is high during the first access whose address bits 31:12 differ from those of ea_i, and only during that access. It is seen on at most one accepted access per instruction.
- R5: A fault response (mem_fault_i high, which takes priority over mem_ack_i) ends the run. That access gets no register write, no later access is issued, and fault_o pulses for one cycle the next cycle. fault_addr_o then holds the faulting address, and done_o does not pulse. Registers written earlier keep their values.
- R6: A load start whose base register number is greater than or equal to the first register number is invalid. invalid_o pulses for one cycle the next cycle, and no memory access or register write follows. Stores are never invalid.
- R7: done_o pulses for exactly one cycle, in the cycle after the accepted response of the access for register 31, and the block is idle in that same cycle.
- R8: start_i is ignored while busy_o is high.
- R9: After reset, busy_o, mem_req_o, rf_we_o, done_o, fault_o and invalid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| is_load_i | input | 1 | 1 = load into registers, 0 = store from registers |
| first_reg_i | input | 5 | First register of the run |
| base_reg_i | input | 5 | Register that supplied the base address |
| ea_i | input | 32 | Effective address of the first word |
| busy_o | output | 1 | Sequence in progress |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Store data |
| mem_ack_i | input | 1 | Access completed |
| mem_fault_i | input | 1 | Access hit a translation fault |
| mem_rdata_i | input | 32 | Load data, valid with mem_ack_i |
| rf_raddr_o | output | 5 | Register being accessed |
| rf_rdata_i | input | 32 | Register read data (combinational) |
| rf_we_o | output | 1 | Register write strobe |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| page_cross_o | output | 1 | Current access is the first one on a new page |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_addr_o | output | 32 | Address of the last faulting access |
| invalid_o | output | 1 | One-cycle invalid-form pulse |

## Verification
A wrong register index or address counter appears on the memory port at the very next accepted access, as a wrong address or wrong store data. It also shows as a wrong total number of accesses by the end of the run. A stale page-cross flag shows either as a second indication or as a missing one at a known access number. Each run is checked against an arithmetic prediction built from the first register, the effective address and the injected fault position. A controller that keeps running after a fault, or that starts on an invalid load, gives extra accesses or register writes within one cycle of the pulse that should have ended the run.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lsm_state_e;

  localparam int WORD_BYTES = 4;

  // address of the following word in the run
  function automatic logic [31:0] step_word(input logic [31:0] a);
    return a + 32'(WORD_BYTES);
  endfunction

  // page frame number of an address for a given page-offset width
  function automatic logic [31:0] frame_of(input logic [31:0] a, input int pb);
    return a >> pb;
  endfunction

  // load whose base register would be overwritten by the run
  function automatic logic base_clobbered(input logic       ld,
                                          input logic [7:0] first,
                                          input logic [7:0] base);
    return ld && (base >= first);
  endfunction

endpackage

// File: rtl/lsm_form_check.sv
module lsm_form_check #(
  parameter int RW = 5
) (
  input  logic          is_load_i,
  input  logic [RW-1:0] first_i,
  input  logic [RW-1:0] base_i,
  output logic          invalid_o
);
  import lsm_pkg::*;

  always_comb begin
    invalid_o = base_clobbered(is_load_i, 8'(first_i), 8'(base_i));
  end

endmodule

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] ea_i,
  input  logic          active_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          cross_o
);
  import lsm_pkg::*;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] origin_q;
  logic          crossed_q;
  logic          off_page;

  assign off_page = frame_of(32'(addr_q), PAGE_BITS) != frame_of(32'(origin_q), PAGE_BITS);
  assign cross_o  = active_i && off_page && !crossed_q;
  assign addr_o   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      origin_q  <= '0;
      crossed_q <= 1'b0;
    end else if (load_i) begin
      addr_q    <= ea_i;
      origin_q  <= ea_i;
      crossed_q <= 1'b0;
    end else if (step_i) begin
      addr_q <= AW'(step_word(32'(addr_q)));
      if (off_page) crossed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl #(
  parameter int NREGS = 32,
  parameter int RW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          is_load_i,
  input  logic [RW-1:0] first_i,
  input  logic          invalid_i,
  input  logic          ack_i,
  input  logic          fault_i,
  output logic          go_o,
  output logic          run_o,
  output logic          accept_o,
  output logic          abort_o,
  output logic          is_load_o,
  output logic [RW-1:0] idx_o,
  output logic          done_o,
  output logic          fault_o,
  output logic          invalid_o
);
  import lsm_pkg::*;

  localparam logic [RW-1:0] LAST_IDX = RW'(NREGS - 1);

  lsm_state_e state_q;
  logic [RW-1:0] idx_q;
  logic          load_q;
  logic          done_q, fault_q, inv_q;
  logic          idle, reject, last;

  assign idle     = (state_q == ST_IDLE);
  assign go_o     = start_i && idle && !invalid_i;
  assign reject   = start_i && idle && invalid_i;
  assign run_o    = (state_q == ST_RUN);
  assign abort_o  = run_o && fault_i;
  assign accept_o = run_o && ack_i && !fault_i;
  assign last     = (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      done_q  <= accept_o && last;
      fault_q <= abort_o;
      inv_q   <= reject;
      if (go_o) begin
        state_q <= ST_RUN;
        idx_q   <= first_i;
        load_q  <= is_load_i;
      end else if (abort_o) begin
        state_q <= ST_IDLE;
      end else if (accept_o) begin
        if (last) state_q <= ST_IDLE;
        else      idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign is_load_o = load_q;
  assign idx_o     = idx_q;
  assign done_o    = done_q;
  assign fault_o   = fault_q;
  assign invalid_o = inv_q;

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int NREGS     = 32,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int RW        = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          is_load_i,
  input  logic [RW-1:0] first_reg_i,
  input  logic [RW-1:0] base_reg_i,
  input  logic [AW-1:0] ea_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic          mem_fault_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          page_cross_o,
  output logic          done_o,
  output logic          fault_o,
  output logic [AW-1:0] fault_addr_o,
  output logic          invalid_o
);

  // internal events, named for the checker
  logic          form_bad;
  logic          go_evt;
  logic          run;
  logic          accept_evt;
  logic          abort_evt;
  logic          load_run;
  logic [RW-1:0] idx;
  logic [AW-1:0] cur_addr;
  logic          cross_now;
  logic [AW-1:0] fault_addr_q;

  lsm_form_check #(.RW(RW)) u_form (
    .is_load_i (is_load_i),
    .first_i   (first_reg_i),
    .base_i    (base_reg_i),
    .invalid_o (form_bad)
  );

  lsm_ctrl #(.NREGS(NREGS), .RW(RW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .is_load_i (is_load_i),
    .first_i   (first_reg_i),
    .invalid_i (form_bad),
    .ack_i     (mem_ack_i),
    .fault_i   (mem_fault_i),
    .go_o      (go_evt),
    .run_o     (run),
    .accept_o  (accept_evt),
    .abort_o   (abort_evt),
    .is_load_o (load_run),
    .idx_o     (idx),
    .done_o    (done_o),
    .fault_o   (fault_o),
    .invalid_o (invalid_o)
  );

  lsm_addr_gen #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (go_evt),
    .ea_i     (ea_i),
    .active_i (run),
    .step_i   (accept_evt),
    .addr_o   (cur_addr),
    .cross_o  (cross_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_addr_q <= '0;
    else if (abort_evt) fault_addr_q <= cur_addr;
  end

  assign busy_o       = run;
  assign mem_req_o    = run;
  assign mem_we_o     = run && !load_run;
  assign mem_addr_o   = cur_addr;
  assign mem_wdata_o  = rf_rdata_i;
  assign rf_raddr_o   = idx;
  assign rf_we_o      = accept_evt && load_run;
  assign rf_waddr_o   = idx;
  assign rf_wdata_o   = mem_rdata_i;
  assign page_cross_o = cross_now;
  assign fault_addr_o = fault_addr_q;

endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int NREGS = 32,
  parameter int AW    = 32,
  parameter int RW    = $clog2(NREGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          is_load_i,
  input logic [RW-1:0] first_reg_i,
  input logic [RW-1:0] base_reg_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          mem_fault_i,
  input logic [RW-1:0] rf_raddr_o,
  input logic          rf_we_o,
  input logic          page_cross_o,
  input logic          done_o,
  input logic          fault_o,
  input logic [AW-1:0] fault_addr_o,
  input logic          invalid_o
);

  localparam logic [RW-1:0] TOP_REG = RW'(NREGS - 1);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i && !mem_fault_i |=>
      mem_req_o && $stable(mem_addr_o) && $stable(rf_raddr_o) && $stable(mem_we_o));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_ack_i && !mem_fault_i && rf_raddr_o != TOP_REG |=>
      mem_req_o && mem_addr_o == $past(mem_addr_o) + 4 && rf_raddr_o == $past(rf_raddr_o) + 1'b1);

  assert_load_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> mem_req_o && mem_ack_i && !mem_fault_i && !mem_we_o);

  assert_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
    page_cross_o |-> mem_req_o);

  assert_fault_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_fault_i |=>
      !mem_req_o && fault_o && !done_o && fault_addr_o == $past(mem_addr_o));

  assert_no_write_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault_i |-> !rf_we_o);

  assert_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && is_load_i && base_reg_i >= first_reg_i |=> invalid_o && !mem_req_o);

  assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_ack_i && !mem_fault_i && rf_raddr_o == TOP_REG |=> done_o && !busy_o);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !mem_ack_i && !mem_fault_i |=> busy_o && $stable(mem_addr_o));

endmodule

bind lsm_seq lsm_seq_chk #(.NREGS(NREGS), .AW(AW), .RW(RW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .is_load_i    (is_load_i),
  .first_reg_i  (first_reg_i),
  .base_reg_i   (base_reg_i),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .mem_fault_i  (mem_fault_i),
  .rf_raddr_o   (rf_raddr_o),
  .rf_we_o      (rf_we_o),
  .page_cross_o (page_cross_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .fault_addr_o (fault_addr_o),
  .invalid_o    (invalid_o)
);

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        start_i, is_load_i;
  logic [4:0]  first_reg_i, base_reg_i;
  logic [31:0] ea_i;
  logic        busy_o, mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_ack_i, mem_fault_i;
  logic [4:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o, page_cross_o, done_o, fault_o, invalid_o;
  logic [31:0] fault_addr_o;

  lsm_seq u_dut (.*);

  function automatic logic [31:0] reg_val(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return ~a ^ 32'h5A5A_1234;
  endfunction

  assign rf_rdata_i  = reg_val(int'(rf_raddr_o));
  assign mem_rdata_i = mem_val(mem_addr_o);

  int n_tests = 0, n_fail = 0;
  int lat_cfg = 0, fault_at = -1, op_base = 0, w_base = 0;
  int acc_idx = 0, nw = 0, wait_cnt = 0;
  int pc_count = 0, pc_idx = -1, done_cnt = 0, fault_cnt = 0, inv_cnt = 0, we_err = 0;
  logic [31:0] fault_seen = '0;
  logic [31:0] addr_log [64];
  logic [31:0] data_log [64];
  logic [4:0]  ridx_log [64];
  logic [4:0]  wreg_log [64];
  logic [31:0] wdat_log [64];
  logic        cur_load = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and monitor
  always @(negedge clk) begin
    if (mem_req_o) begin
      if (wait_cnt >= lat_cfg) begin
        if (acc_idx - op_base == fault_at) begin mem_fault_i = 1'b1; mem_ack_i = 1'b0; end
        else begin mem_ack_i = 1'b1; mem_fault_i = 1'b0; end
        wait_cnt = 0;
      end else begin
        mem_ack_i = 1'b0; mem_fault_i = 1'b0; wait_cnt++;
      end
    end else begin
      mem_ack_i = 1'b0; mem_fault_i = 1'b0; wait_cnt = 0;
    end
    #1;
    if (mem_req_o && mem_ack_i) begin
      addr_log[acc_idx % 64] = mem_addr_o;
      data_log[acc_idx % 64] = mem_wdata_o;
      ridx_log[acc_idx % 64] = rf_raddr_o;
      if (mem_we_o == cur_load) we_err++;
      if (page_cross_o) begin pc_count++; pc_idx = acc_idx - op_base; end
      acc_idx++;
    end
    if (rf_we_o) begin
      wreg_log[nw % 64] = rf_waddr_o;
      wdat_log[nw % 64] = rf_wdata_o;
      nw++;
    end
    if (done_o) done_cnt++;
    if (fault_o) begin fault_cnt++; fault_seen = fault_addr_o; end
    if (invalid_o) inv_cnt++;
  end

  task automatic run_op(input int first, input int base, input bit ld, input logic [31:0] ea,
                        input int lat, input int fidx, input bit mid_start);
    int d0, f0, i0, n, n_ok, exp_pc, exp_pci;
    bit bad;
    bad  = ld && (base >= first);
    n    = 32 - first;
    n_ok = (fidx >= 0 && fidx < n) ? fidx : n;
    exp_pc = 0; exp_pci = -1;
    for (int i = 0; i < n_ok; i++)
      if (exp_pc == 0 && ((ea + 32'(4*i)) >> 12) != (ea >> 12)) begin exp_pc = 1; exp_pci = i; end
    @(negedge clk);
    lat_cfg = lat; fault_at = fidx; op_base = acc_idx; w_base = nw;
    d0 = done_cnt; f0 = fault_cnt; i0 = inv_cnt; pc_count = 0; pc_idx = -1; we_err = 0;
    cur_load = ld;
    start_i = 1'b1; is_load_i = ld; first_reg_i = 5'(first); base_reg_i = 5'(base); ea_i = ea;
    @(negedge clk);
    if (mid_start) begin
      is_load_i = ~ld; first_reg_i = 5'd0; base_reg_i = 5'd31; ea_i = 32'hDEAD_0000;
      repeat (3) @(negedge clk);
    end
    start_i = 1'b0;
    for (int t = 0; t < 400 && busy_o; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    #2;
    if (bad) begin
      chk(inv_cnt - i0 == 1, "R6 invalid pulse", 32'(inv_cnt - i0), 1);
      chk(acc_idx == op_base && nw == w_base, "R6 no activity", 32'(acc_idx - op_base), 0);
      return;
    end
    chk(inv_cnt == i0, "R6 valid form not flagged", 32'(inv_cnt - i0), 0);
    chk(acc_idx - op_base == n_ok, "R1 access count", 32'(acc_idx - op_base), 32'(n_ok));
    for (int i = 0; i < n_ok; i++) begin
      chk(addr_log[(op_base+i)%64] == ea + 32'(4*i), "R2 address", addr_log[(op_base+i)%64], ea + 32'(4*i));
      chk(ridx_log[(op_base+i)%64] == 5'(first+i), "R1 register order", 32'(ridx_log[(op_base+i)%64]), 32'(first+i));
      if (!ld)
        chk(data_log[(op_base+i)%64] == reg_val(first+i), "R3 store data", data_log[(op_base+i)%64], reg_val(first+i));
      else begin
        chk(wreg_log[(w_base+i)%64] == 5'(first+i), "R3 load index", 32'(wreg_log[(w_base+i)%64]), 32'(first+i));
        chk(wdat_log[(w_base+i)%64] == mem_val(ea + 32'(4*i)), "R3 load data", wdat_log[(w_base+i)%64], mem_val(ea + 32'(4*i)));
      end
    end
    chk(we_err == 0, "R3 write enable direction", 32'(we_err), 0);
    chk(nw - w_base == (ld ? n_ok : 0), "R3 register write count", 32'(nw - w_base), 32'(ld ? n_ok : 0));
    chk(pc_count == exp_pc && pc_idx == exp_pci, "R4 page cross", 32'(pc_idx), 32'(exp_pci));
    if (n_ok < n) begin
      chk(fault_cnt - f0 == 1, "R5 fault pulse", 32'(fault_cnt - f0), 1);
      chk(fault_seen == ea + 32'(4*n_ok), "R5 fault address", fault_seen, ea + 32'(4*n_ok));
      chk(done_cnt == d0, "R5 no done after fault", 32'(done_cnt - d0), 0);
    end else begin
      chk(done_cnt - d0 == 1, "R7 one done pulse", 32'(done_cnt - d0), 1);
      chk(fault_cnt == f0, "R7 no fault", 32'(fault_cnt - f0), 0);
    end
    chk(!busy_o, "R7 idle after run", 32'(busy_o), 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        rst_n = 1'b0; start_i = 1'b0; is_load_i = 1'b0; first_reg_i = '0; base_reg_i = '0; ea_i = '0;
        mem_ack_i = 1'b0; mem_fault_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy_o && !mem_req_o && !rf_we_o && !done_o && !fault_o && !invalid_o,
            "R9 reset state", {26'd0, busy_o, mem_req_o, rf_we_o, done_o, fault_o, invalid_o}, 0);
        // store sweep, base inside range is legal for stores (R6)
        for (int f = 0; f < 32; f++)
          run_op(f, f, 1'b0, 32'h0000_1000 - 32'(4*(f % 5)), f % 3, -1, 1'b0);
        // load sweep with base below the range
        for (int f = 1; f < 32; f++)
          run_op(f, f - 1, 1'b1, 32'h0002_3FF0 + 32'(4*(f % 3)), (f + 1) % 3, -1, 1'b0);
        // invalid loads: base inside the destination range (R6)
        for (int f = 0; f < 32; f += 3)
          run_op(f, f + (31 - f) / 2, 1'b1, 32'h100, 0, -1, 1'b0);
        run_op(31, 31, 1'b1, 32'h200, 0, -1, 1'b0);
        // faults on the second page and on the first access (R5)
        run_op(20, 3, 1'b1, 32'h0000_2FF8, 1, 4, 1'b0);
        run_op(10, 2, 1'b0, 32'h0000_5FFC, 0, 1, 1'b0);
        run_op(0, 0, 1'b0, 32'h0000_0FF0, 2, 0, 1'b0);
        run_op(25, 1, 1'b1, 32'h0000_7000, 0, 6, 1'b0);
        // start held high while busy must be ignored (R8)
        run_op(4, 0, 1'b0, 32'h0000_3FF4, 1, -1, 1'b1);
        run_op(8, 2, 1'b1, 32'h0000_8000, 0, -1, 1'b1);
      end
      begin
        while (wd < 150000) begin @(negedge clk); wd++; end
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", wd);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule